// File: doc/BRIEF.md
# RTC interrupt flag controller

This block gathers the three interrupt causes of a PC-style real-time clock (a periodic tick, an alarm match and an end-of-update event) and presents them to software as a byte-wide flag register and one active-high interrupt line. Alarm and update causes arrive as one-cycle pulses from neighbouring logic. The periodic cause is produced inside the block. A divider counts pulses of a 32.768 kHz clock-enable input, and a rate field sets the division.

Each cause has an enable bit in a control register. The flag of a cause sits at the same bit position as its enable, so one mask covers both. A flag is latched whenever its event happens, whatever the enable says. A summary bit is the OR of the flags that are enabled. Software reads the flag register to learn the cause, and that read also acknowledges every flag. The interrupt line is driven by a small two-state machine. State `LINE_QUIET` moves to `LINE_RAISED` at a clock edge after which the summary is true. State `LINE_RAISED` moves back to `LINE_QUIET` at an edge after which the summary is false. Each state otherwise holds.

Three registers are selected by `addr`:
- 0 is the rate register: bits 6:4 select the reference, bits 3:0 set the rate.
- 1 is the control register.
- 2 is the flag register, which is read-only.

Address 3 reads zero.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset the rate register reads 0x26, the control register reads 0x02, the flag register reads 0x00 and `irq` is low.
- R2: A periodic, alarm or update event sets its flag even when its enable is clear. The flag bits are periodic at bit 6, alarm at bit 5 and update at bit 4. A flag never rises without its event in the previous cycle.
- R3: The flag register reads {summary, periodic, alarm, update, 4'b0000}. The summary is set exactly when some flag is set together with its enable. The enables are periodic at bit 6, alarm at bit 5 and update at bit 4 of the control register.
- R4: `irq` equals the summary bit. It rises in the cycle that follows the clock edge that sets an enabled flag.
- R5: A read of the flag register (`rd_en` with `addr`=2) clears all flags. `irq` is low from the next cycle, unless a new enabled event arrives in the same cycle.
- R6: An event that arrives in the same cycle as a flag-register read is set after that read, so no event is lost.
- R7: With reference select 3'b010 and rate r in 1..15, the periodic flag is set once every 2^(r-1) reference pulses. With r = 0 it is never set.
- R8: With any reference select other than 3'b010, the periodic flag is never set.
- R9: Writing an enable for a flag that is already latched raises `irq` in the cycle after the write.
- R10: Writes to the flag register have no effect. In the control register only bits 6, 5, 4, 2 (data mode) and 1 (24-hour mode) hold data. In the rate register only bits 6:0 hold data. All other bits read zero.
- R11: A write to the rate register restarts the divider. The first periodic flag comes at the clock edge 2^(r-1)+1 cycles after the write edge, counted with the reference pulse held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 2 | Register select: 0 rate, 1 control, 2 flags |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; on address 2 it acknowledges all flags |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| alarm_evt | input | 1 | One-cycle alarm match pulse |
| update_evt | input | 1 | One-cycle end-of-update pulse |
| ref_tick | input | 1 | 32.768 kHz clock-enable pulse |
| irq | output | 1 | Active-high interrupt request |

## Verification
A wrong internal state shows at the ports within one or two cycles. A mis-latched or lost flag changes the flag byte at the next read. A wrong summary or a wrong line state puts `irq` out of step with that byte from the cycle after the edge that set the flag. A faulty divider count moves the first periodic flag after a rate write, or changes the spacing between flags. The bench measures both against 2^(r-1) for every rate from 3 to 15. The full cross of the three enables with the three event sources is swept, and every case is followed by a read that must also drop the line.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
    // internal source vector order: periodic, alarm, update
    localparam int SRC_N     = 3;
    localparam int SRC_LSB   = 4;   // sources occupy bits 6:4 in flag and control bytes
    localparam int SUM_BIT   = 7;
    localparam logic [7:0] CTRL_MASK  = 8'h76;
    localparam logic [7:0] RATE_RESET = 8'h26;
    localparam logic [7:0] CTRL_RESET = 8'h02;
    localparam logic [2:0] REF_32K    = 3'b010;

    typedef enum logic [1:0] {
        REG_RATE = 2'd0,
        REG_CTRL = 2'd1,
        REG_FLAG = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        LINE_QUIET  = 1'b0,
        LINE_RAISED = 1'b1
    } line_state_e;
endpackage

// File: rtl/rtc_irq_divider.sv
module rtc_irq_divider #(
    parameter int RATE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              enable,
    input  logic              restart,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int CNT_W = (1 << RATE_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic             active;

    always_comb begin
        active = enable && (rate != '0);
        if (rate == '0) begin
            last = '0;
        end else begin
            last = (CNT_W'(1) << (rate - RATE_W'(1))) - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (restart || !active) begin
                cnt <= '0;
            end else if (ref_tick) begin
                if (cnt == last) begin
                    cnt  <= '0;
                    tick <= 1'b1;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

    // R7
    tick_needs_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(ref_tick && active));
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         ack,
    input  logic [N-1:0] en_d,
    output logic [N-1:0] flags_q,
    output logic         summary_d
);
    logic [N-1:0] flags_d;

    always_comb begin
        flags_d   = (ack ? '0 : flags_q) | evt;
        summary_d = |(flags_d & en_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R6
        evt_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> flags_q[i]);
        // R2
        flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags_q[i]) |-> $past(evt[i]));
    end
endmodule

// File: rtl/rtc_irq_line.sv
module rtc_irq_line
    import rtc_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic summary_d,
    output logic irq
);
    line_state_e state_q;
    line_state_e state_d;

    always_comb begin
        unique case (state_q)
            LINE_QUIET:  state_d = summary_d ? LINE_RAISED : LINE_QUIET;
            LINE_RAISED: state_d = summary_d ? LINE_RAISED : LINE_QUIET;
            default:     state_d = LINE_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LINE_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq = (state_q == LINE_RAISED);
    end
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
#(
    parameter int RATE_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       alarm_evt,
    input  logic       update_evt,
    input  logic       ref_tick,
    output logic       irq
);
    localparam int SEL_LSB = RATE_W;
    localparam int SRC_MSB = SRC_LSB + SRC_N - 1;

    reg_sel_e         sel;
    logic [6:0]       rate_q;
    logic [7:0]       ctrl_q;
    logic [7:0]       ctrl_d;
    logic             wr_rate;
    logic             wr_ctrl;
    logic             ack;
    logic             per_tick;
    logic [SRC_N-1:0] evt;
    logic [SRC_N-1:0] flags_q;
    logic             summary_d;
    logic             summary_now;

    always_comb begin
        sel     = reg_sel_e'(addr);
        wr_rate = wr_en && (sel == REG_RATE);
        wr_ctrl = wr_en && (sel == REG_CTRL);
        ack     = rd_en && (sel == REG_FLAG);
        ctrl_d  = wr_ctrl ? (wdata & CTRL_MASK) : ctrl_q;
        evt     = {per_tick, alarm_evt, update_evt};
        summary_now = |(flags_q & ctrl_q[SRC_MSB:SRC_LSB]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q <= RATE_RESET[6:0];
            ctrl_q <= CTRL_RESET;
        end else begin
            if (wr_rate) begin
                rate_q <= wdata[6:0];
            end
            ctrl_q <= ctrl_d;
        end
    end

    always_comb begin
        unique case (sel)
            REG_RATE: rdata = {1'b0, rate_q};
            REG_CTRL: rdata = ctrl_q;
            REG_FLAG: rdata = {summary_now, flags_q, 4'b0000};
            default:  rdata = 8'h00;
        endcase
    end

    rtc_irq_divider #(.RATE_W(RATE_W)) u_divider (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .enable   (rate_q[6:SEL_LSB] == REF_32K),
        .restart  (wr_rate),
        .rate     (rate_q[RATE_W-1:0]),
        .tick     (per_tick)
    );

    rtc_irq_flags #(.N(SRC_N)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .ack       (ack),
        .en_d      (ctrl_d[SRC_MSB:SRC_LSB]),
        .flags_q   (flags_q),
        .summary_d (summary_d)
    );

    rtc_irq_line u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .summary_d (summary_d),
        .irq       (irq)
    );

    // R4
    irq_matches_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == summary_now);
    // R5
    ack_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !alarm_evt && !update_evt && !per_tick) |=> !irq);
endmodule

// File: tb/rtc_irq_ctrl_bench.sv
`timescale 1ns/1ps
module rtc_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       alarm_evt = 1'b0;
    logic       update_evt = 1'b0;
    logic       ref_tick = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rtc_irq_ctrl u_rtc_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .alarm_evt(alarm_evt),
        .update_evt(update_evt), .ref_tick(ref_tick), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // every task starts just after a falling edge and uses one rising edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic a, input logic u, input logic r);
        alarm_evt = a; update_evt = u; ref_tick = r;
        @(negedge clk);
        alarm_evt = 1'b0; update_evt = 1'b0; ref_tick = 1'b0;
    endtask

    task automatic run_all();
        logic [7:0] d;
        int hits;

        // R1 reset state
        rd(2'd0, d); chk("R1 rate reset", d, 8'h26);
        rd(2'd1, d); chk("R1 ctrl reset", d, 8'h02);
        rd(2'd2, d); chk("R1 flag reset", d, 8'h00);
        chk("R1 irq reset", irq, 0);

        // R2 flag latched with enable clear
        pulse(1'b1, 1'b0, 1'b0);
        chk("R2 irq stays low", irq, 0);
        rd(2'd2, d); chk("R2 alarm flag raw", d, 8'h20);
        rd(2'd2, d); chk("R5 flags cleared", d, 8'h00);

        // R9 enable after latch
        pulse(1'b0, 1'b1, 1'b0);
        chk("R9 irq before enable", irq, 0);
        wr(2'd1, 8'h12);
        chk("R9 irq after enable", irq, 1);
        rd(2'd2, d); chk("R3 update summary", d, 8'h90);
        chk("R5 irq after ack", irq, 0);

        // R3 R4 R5 sweep: every enable set against every source set
        wr(2'd0, 8'h20);
        for (int e = 0; e < 8; e++) begin
            for (int s = 0; s < 8; s++) begin
                logic exp_irq;
                wr(2'd1, 8'((e << 4) | 8'h02));
                rd(2'd2, d);
                if (s[2]) begin
                    wr(2'd0, 8'h21);
                    pulse(1'b0, 1'b0, 1'b1);
                    wr(2'd0, 8'h20);
                end
                if (s[1] || s[0]) pulse(s[1], s[0], 1'b0);
                exp_irq = |(e[2:0] & s[2:0]);
                chk("R4 irq sweep", irq, exp_irq);
                rd(2'd2, d);
                chk("R3 flag byte sweep", d, {exp_irq, s[2:0], 4'b0000});
                chk("R5 irq low after read", irq, 0);
            end
        end

        // R6 event in the read cycle
        wr(2'd1, 8'h22);
        rd(2'd2, d);
        addr = 2'd2; rd_en = 1'b1; alarm_evt = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0; alarm_evt = 1'b0;
        chk("R6 read shows old", d, 8'h00);
        chk("R6 irq kept", irq, 1);
        rd(2'd2, d); chk("R6 alarm not lost", d, 8'hA0);

        // R10 write masks
        pulse(1'b0, 1'b1, 1'b0);
        wr(2'd2, 8'hFF);
        rd(2'd2, d); chk("R10 flag write ignored", d, 8'h10);
        wr(2'd1, 8'hFF);
        rd(2'd1, d); chk("R10 ctrl mask", d, 8'h76);
        wr(2'd0, 8'hFF);
        rd(2'd0, d); chk("R10 rate mask", d, 8'h7F);

        // R8 wrong reference select, R7 rate zero
        wr(2'd1, 8'h42);
        wr(2'd0, 8'h03);
        rd(2'd2, d);
        ref_tick = 1'b1;
        hits = 0;
        for (int k = 0; k < 60; k++) begin
            if (irq) hits++;
            @(negedge clk);
        end
        rd(2'd2, d);
        chk("R8 no tick off-reference", hits, 0);
        chk("R8 periodic flag clear", d, 8'h00);
        wr(2'd0, 8'h20);
        rd(2'd2, d);
        hits = 0;
        for (int k = 0; k < 60; k++) begin
            if (irq) hits++;
            @(negedge clk);
        end
        rd(2'd2, d);
        chk("R7 rate zero silent", hits, 0);
        chk("R7 rate zero flag", d, 8'h00);

        // R7 R11 rate sweep, reference pulse held high
        for (int r = 3; r <= 15; r++) begin
            int p;
            int w;
            int first;
            int second;
            int seen;
            p = 1 << (r - 1);
            first = 0; second = 0; seen = 0;
            wr(2'd0, 8'h20);
            rd(2'd2, d);
            wr(2'd0, 8'(8'h20 | r));
            w = cyc;
            for (int k = 0; k < 2 * p + 10 && seen < 2; k++) begin
                addr = 2'd2; rd_en = 1'b0;
                if (irq) begin
                    if (seen == 0) first = cyc; else second = cyc;
                    seen++;
                    rd_en = 1'b1;
                end
                @(negedge clk);
            end
            rd_en = 1'b0;
            chk("R7 two periodic flags", seen, 2);
            chk("R11 first flag after write", first - w, p + 1);
            chk("R7 periodic spacing", second - first, p);
        end
        ref_tick = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        fork
            run_all();
            begin
                repeat (180000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule